// File: doc/BRIEF.md
# Spindle Motor Start and Protection Supervisor

This block sequences a spindle motor driver from stop to run and protects it while it runs. Its timing comes from a slow timebase: a one-cycle `tick` strobe on the system clock. When the start request arrives, it first holds the control logic in an initial reset for a set number of ticks. Only after that does it let the power stage drive. While running, it watches the rotor feedback pulse (FG) for a stalled rotor and watches the speed reference clock for loss of signal.

A stall is declared when no rising FG edge arrives within a tick window. A stall removes drive, and the stall state is held until the start request is withdrawn. When the reference clock stops, normal control is dropped and the block enters intermittent mode. In that mode drive is withheld and an indication is raised. Drive comes back if the clock returns before the stall window expires; after that point only a stop clears the fault.

The power stage obeys the drive-enable output. The encoded state is brought out so that a controller or testbench can tell the phases apart.

Top module: `spin_supervisor`

## Requirements
- R1: While `run_n` is high (stop), `state_o` is 3'b000 (stop), `drive_en` is 0 and `intermit` is 0. A synchronous reset (`rst_n` low) also puts the block in this state.
- R2: When `run_n` goes low in the stop state, `state_o` becomes 3'b001 (initial reset) and `drive_en` stays 0 for RESET_TICKS ticks.
- R3: At the end of the initial reset, `state_o` becomes 3'b010 (run) and `drive_en` is 1.
- R4: In run or intermittent state, if STALL_TICKS ticks (default 31) pass with no rising FG edge, `state_o` becomes 3'b100 (stalled) and `drive_en` is 0. Regular FG edges prevent this.
- R5: The stalled state is latched. FG and reference clock activity have no effect on it, and only `run_n` high (to stop) or `rst_n` clears it.
- R6: In run state, if CUTOFF_TICKS ticks (default 2) pass with no falling reference clock edge, `state_o` becomes 3'b011 (intermittent), `drive_en` is 0 and `intermit` is 1.
- R7: In intermittent state, a falling reference clock edge that arrives before the stall timeout returns the block to run with `drive_en` 1.
- R8: A start with no reference clock gives a brief run with `drive_en` 1, then intermittent. If the clock stays absent for the stall window the block latches stalled, and a clock that returns later does not restore drive.
- R9: With parameter STALL_EN = 0 the stall timeout never fires, while the initial reset interval still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe; all timeouts count these |
| run_n | input | 1 | Start request, active low (high = stop) |
| fg_in | input | 1 | Rotor feedback pulse, asynchronous |
| ref_in | input | 1 | Speed reference clock, asynchronous |
| drive_en | output | 1 | Power stage may drive the motor |
| intermit | output | 1 | Reference clock lost, intermittent mode |
| state_o | output | 3 | Encoded supervisor state |

## Verification
The hardest situation to reach is the race between a returning reference clock and the stall window while the block sits in intermittent mode. Reaching it needs FG to be silent and the clock absent at the same time. The clock must then come back on the near side of the window once, and on the far side in another run.

The stimulus walks a vector table in which the FG and reference generators are switched on and off independently. The tick strobe divides the clock by four. The wait lengths in the table are chosen so that each sample falls well clear of the window edge, whatever phase the tick and the free-running generators happen to be in.

A directed test then watches drive during a clockless start to catch the brief run.

// File: rtl/spin_pkg.sv
// Package: shared state encoding for the spindle start/protection supervisor.
// Assumes: the encoding is visible on the top-level state output and is
// therefore fixed.
package spin_pkg;
    typedef enum logic [2:0] {
        ST_STOP  = 3'b000,
        ST_RESET = 3'b001,
        ST_RUN   = 3'b010,
        ST_INTER = 3'b011,
        ST_STALL = 3'b100
    } spin_state_e;
endpackage

// File: rtl/edge_sync.sv
// Module: edge_sync
// Brings an asynchronous input into the clock domain through SYNC_N flops and
// emits a one-cycle pulse on the selected edge (FALLING = 0 rising, 1 falling).
// Assumes: the input stays at each level for longer than SYNC_N + 1 clocks.
module edge_sync #(
    parameter int SYNC_N  = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic [SYNC_N-1:0] sh_q;
    logic              prev_q;
    logic              lvl;

    assign lvl = sh_q[SYNC_N-1];

    // Synchronizer chain plus a delayed copy for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[SYNC_N-2:0], din};
            prev_q <= lvl;
        end
    end

    // Polarity variant chosen by parameter.
    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev_q & ~lvl;
        end else begin : g_rise
            assign edge_o = ~prev_q & lvl;
        end
    endgenerate

    // R4: an edge pulse lasts one clock only.
    a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/tick_timer.sv
// Module: tick_timer
// Counts timebase ticks from a clear and saturates at LIMIT. The hit output
// stays high once LIMIT ticks have elapsed, until the next clear.
// Assumes: clr has priority over tick.
module tick_timer #(
    parameter int LIMIT = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    assign hit = (cnt_q >= LIM);

    // Saturating tick counter with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick && !hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: the count never runs past its limit.
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
endmodule

// File: rtl/spin_supervisor.sv
// Module: spin_supervisor (top)
// Start sequencing and protection for a spindle motor driver. It applies an
// initial reset interval on start, latches a stall when FG edges stop, and
// enters intermittent mode when the reference clock is lost. drive_en gates
// the power stage.
// Assumes: tick is a one-cycle strobe; run_n, fg_in and ref_in are
// asynchronous and are synchronized here.
module spin_supervisor
    import spin_pkg::*;
#(
    parameter int RESET_TICKS  = 4,
    parameter int STALL_TICKS  = 31,
    parameter int CUTOFF_TICKS = 2,
    parameter bit STALL_EN     = 1'b1,
    parameter int SYNC_N       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run_n,
    input  logic       fg_in,
    input  logic       ref_in,
    output logic       drive_en,
    output logic       intermit,
    output logic [2:0] state_o
);
    spin_state_e       state_q, state_d;
    logic [SYNC_N-1:0] stop_sh_q;
    logic              stop_s;
    logic              fg_edge, ref_edge;
    logic              rst_hit, stall_hit, cut_hit;
    logic              active;

    assign stop_s = stop_sh_q[SYNC_N-1];
    assign active = (state_q == ST_RUN) || (state_q == ST_INTER);

    // Start/stop synchronizer; comes out of reset reading stop.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_sh_q <= '1;
        else        stop_sh_q <= {stop_sh_q[SYNC_N-2:0], run_n};
    end

    edge_sync #(.SYNC_N(SYNC_N), .FALLING(1'b0)) u_fg_sync (
        .clk(clk), .rst_n(rst_n), .din(fg_in), .edge_o(fg_edge));

    edge_sync #(.SYNC_N(SYNC_N), .FALLING(1'b1)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .din(ref_in), .edge_o(ref_edge));

    tick_timer #(.LIMIT(RESET_TICKS)) u_rst_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .clr(state_q != ST_RESET), .hit(rst_hit));

    tick_timer #(.LIMIT(CUTOFF_TICKS)) u_cut_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .clr(ref_edge || !active), .hit(cut_hit));

    // Stall timer present only when the protection is enabled.
    generate
        if (STALL_EN) begin : g_stall
            tick_timer #(.LIMIT(STALL_TICKS)) u_stall_tmr (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .clr(fg_edge || !active), .hit(stall_hit));
        end else begin : g_nostall
            assign stall_hit = 1'b0;
        end
    endgenerate

    // Next-state logic; stop overrides every state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (!stop_s) state_d = ST_RESET;
            ST_RESET: if (rst_hit) state_d = ST_RUN;
            ST_RUN: begin
                if (stall_hit)    state_d = ST_STALL;
                else if (cut_hit) state_d = ST_INTER;
            end
            ST_INTER: begin
                if (stall_hit)     state_d = ST_STALL;
                else if (ref_edge) state_d = ST_RUN;
            end
            ST_STALL: state_d = ST_STALL;
            default:  state_d = ST_STOP;
        endcase
        if (stop_s) state_d = ST_STOP;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    assign drive_en = (state_q == ST_RUN);
    assign intermit = (state_q == ST_INTER);
    assign state_o  = state_q;

    // R1: a synchronized stop reaches the stop state one clock later.
    a_r1_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stop_s |=> state_q == ST_STOP);
    // R2: run is never entered directly from stop or stalled.
    a_r2_no_skip_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP || state_q == ST_STALL) |=> state_q != ST_RUN);
    // R5: the stalled state holds until stop.
    a_r5_stall_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL && !stop_s) |=> state_q == ST_STALL);
    // R6: cutoff in run moves to intermittent.
    a_r6_cut_to_inter: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cut_hit && !stall_hit && !stop_s) |=> state_q == ST_INTER);
    // R7: a returning reference edge in intermittent restores run.
    a_r7_inter_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTER && ref_edge && !stall_hit && !stop_s) |=> state_q == ST_RUN);
endmodule

// File: tb/spin_supervisor_tb.sv
module spin_supervisor_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic run_n = 1'b1;
    logic fg_in = 1'b0;
    logic ref_in = 1'b0;
    logic fg_on = 1'b1;
    logic ref_on = 1'b1;
    logic       drive_en, intermit, drive_ns, inter_ns;
    logic [2:0] state_o, state_ns;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spin_supervisor u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_n(run_n),
        .fg_in(fg_in), .ref_in(ref_in),
        .drive_en(drive_en), .intermit(intermit), .state_o(state_o));

    spin_supervisor #(.STALL_EN(1'b0)) u_dut_ns (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_n(run_n),
        .fg_in(fg_in), .ref_in(ref_in),
        .drive_en(drive_ns), .intermit(inter_ns), .state_o(state_ns));

    // Timebase: one tick every 4 clocks.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // Reference clock generator: falling edge every 4 clocks when enabled.
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            if (ref_on) ref_in = ~ref_in;
        end
    end

    // FG generator: rising edge every 16 clocks when enabled.
    initial begin
        forever begin
            repeat (8) @(negedge clk);
            if (fg_on) fg_in = ~fg_in;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [2:0] st, input logic drv, input logic inr);
        check(state_o == st, req, int'(state_o), int'(st));
        check(drive_en == drv, req, int'(drive_en), int'(drv));
        check(intermit == inr, req, int'(intermit), int'(inr));
    endtask

    // Row: run_n, ref_on, fg_on, wait[15:0], state[2:0], drive, intermit, req[3:0]
    localparam int NROW = 19;
    localparam logic [27:0] TBL [NROW] = '{
        {1'b1, 1'b1, 1'b1, 16'd20,  3'd0, 1'b0, 1'b0, 4'd1},  // R1 stop
        {1'b0, 1'b1, 1'b1, 16'd6,   3'd1, 1'b0, 1'b0, 4'd2},  // R2 initial reset
        {1'b0, 1'b1, 1'b1, 16'd30,  3'd2, 1'b1, 1'b0, 4'd3},  // R3 run
        {1'b0, 1'b1, 1'b1, 16'd200, 3'd2, 1'b1, 1'b0, 4'd4},  // R4 FG keeps it alive
        {1'b0, 1'b0, 1'b1, 16'd30,  3'd3, 1'b0, 1'b1, 4'd6},  // R6 clock lost
        {1'b0, 1'b1, 1'b1, 16'd12,  3'd2, 1'b1, 1'b0, 4'd7},  // R7 clock back
        {1'b0, 1'b1, 1'b0, 16'd90,  3'd2, 1'b1, 1'b0, 4'd4},  // R4 within window
        {1'b0, 1'b1, 1'b0, 16'd50,  3'd4, 1'b0, 1'b0, 4'd4},  // R4 stall
        {1'b0, 1'b1, 1'b1, 16'd200, 3'd4, 1'b0, 1'b0, 4'd5},  // R5 latched
        {1'b1, 1'b1, 1'b1, 16'd10,  3'd0, 1'b0, 1'b0, 4'd5},  // R5 cleared by stop
        {1'b0, 1'b0, 1'b0, 16'd50,  3'd3, 1'b0, 1'b1, 4'd8},  // R8 clockless start
        {1'b0, 1'b0, 1'b0, 16'd60,  3'd3, 1'b0, 1'b1, 4'd8},  // R8 still waiting
        {1'b0, 1'b0, 1'b0, 16'd60,  3'd4, 1'b0, 1'b0, 4'd8},  // R8 stall window over
        {1'b0, 1'b1, 1'b1, 16'd30,  3'd4, 1'b0, 1'b0, 4'd8},  // R8 late clock ignored
        {1'b1, 1'b1, 1'b1, 16'd10,  3'd0, 1'b0, 1'b0, 4'd1},  // R1 stop
        {1'b0, 1'b1, 1'b1, 16'd40,  3'd2, 1'b1, 1'b0, 4'd3},  // R3 run again
        {1'b0, 1'b0, 1'b0, 16'd40,  3'd3, 1'b0, 1'b1, 4'd6},  // R6 clock lost
        {1'b0, 1'b1, 1'b0, 16'd40,  3'd2, 1'b1, 1'b0, 4'd7},  // R7 early return
        {1'b1, 1'b1, 1'b1, 16'd10,  3'd0, 1'b0, 1'b0, 4'd1}   // R1 stop
    };

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit saw_drive;
        repeat (4) @(negedge clk);
        check_out("R1 reset", 3'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NROW; i++) begin
            logic [27:0] r;
            r = TBL[i];
            run_n  = r[27];
            ref_on = r[26];
            fg_on  = r[25];
            repeat (int'(r[24:9])) @(negedge clk);
            check_out($sformatf("row%0d R%0d", i, r[3:0]), r[8:6], r[5], r[4]);
        end

        // R1: synchronous reset in the middle of a run.
        run_n = 1'b0; ref_on = 1'b1; fg_on = 1'b1;
        repeat (40) @(negedge clk);
        check_out("R3 pre-reset run", 3'd2, 1'b1, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_out("R1 mid-run reset", 3'd0, 1'b0, 1'b0);
        run_n = 1'b1;
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R8: a clockless start shows a brief drive before intermittent.
        ref_on = 1'b0; fg_on = 1'b1;
        run_n = 1'b0;
        saw_drive = 1'b0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (drive_en) saw_drive = 1'b1;
        end
        check(saw_drive, "R8 brief drive", int'(saw_drive), 1);
        check_out("R8 then intermittent", 3'd3, 1'b0, 1'b1);
        run_n = 1'b1;
        repeat (10) @(negedge clk);

        // R9: without stall protection, FG silence does not stop drive.
        ref_on = 1'b1; fg_on = 1'b0;
        run_n = 1'b0;
        repeat (6) @(negedge clk);
        check(state_ns == 3'd1, "R9 reset interval kept", int'(state_ns), 1);
        check(drive_ns == 1'b0, "R9 no drive in reset", int'(drive_ns), 0);
        repeat (200) @(negedge clk);
        check(state_o == 3'd4, "R4 protected copy stalls", int'(state_o), 4);
        check(state_ns == 3'd2, "R9 unprotected copy runs", int'(state_ns), 2);
        check(drive_ns == 1'b1, "R9 unprotected drive", int'(drive_ns), 1);
        run_n = 1'b1;
        repeat (10) @(negedge clk);
        check_out("R1 final stop", 3'd0, 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule